// File: doc/BRIEF.md
# Quad-Rate Burst SRAM Port Model

This block is a cycle-accurate, synthesizable stand-in for a quad-data-rate burst memory. It has one input clock. Each clock cycle carries two half-cycle sub-words: a rise beat and a fall beat. Reads and writes have their own data ports and may run in the same cycle. They share one address bus, which also carries two sub-words per cycle. The read address is taken from the rise half (`addr_rise`) and the write address from the fall half (`addr_fall`).

Every access is a burst of four words that stays inside one four-word row. The burst starts at the word named by the two low address bits and counts upward, wrapping modulo four. A command takes two cycles of its port, so each port can start a new burst every other cycle.

Write beats arrive over the two cycles after the write command, with per-byte enables on each beat. Read beats leave with a fixed latency of one and a half cycles and carry per-half valid flags.

There is no back-pressure anywhere. The memory accepts every command that falls on a free slot. The read stream cannot be stalled, so a consumer must take each beat in the half-cycle in which its valid flag is high.

Top module: `qdr_sram_model`

## Requirements
- R1: After reset, `rvalid_rise` and `rvalid_fall` are low. Whenever a valid flag is low, its data port reads all zeros.
- R2: A read accepted at the end of cycle t puts beat 0 on the fall port in cycle t+1, beats 1 and 2 on the rise and fall ports in cycle t+2, and beat 3 on the rise port in cycle t+3. The valid flags are high for exactly these four half-cycles.
- R3: Burst beat k of an access at address A is the word at row A[ADDR_W-1:2], word index (A[1:0]+k) mod 4.
- R4: Write beats 0 and 1 are taken from the rise and fall write data ports in the cycle after the write command. Beats 2 and 3 are taken in the cycle after that. They are stored in the same wrapping order as in R3.
- R5: Byte lane i covers data bits [9i+8:9i]. The lane is written only when bit i of the active-low enable for that beat (`ben_rise_n` or `ben_fall_n`) is 0. Otherwise the stored byte keeps its value.
- R6: For each port separately, a select (`rd_n` or `wr_n` low) in the cycle right after an accepted command of that port is ignored. Commands on the other port are not affected.
- R7: A read and a write commanded in the same cycle to the same row both complete. The read returns the data stored before that write.
- R8: A write commanded in cycle t becomes visible to reads commanded in cycle t+3 or later. A read commanded in cycle t+2 still sees the old data.
- R9: Under any mix of concurrent reads and writes, every read beat equals the value given by R3 to R8. Reads commanded every two cycles give an unbroken stream of beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; one cycle holds a rise and a fall sub-word |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_n | input | 1 | Active-low read select |
| wr_n | input | 1 | Active-low write select |
| addr_rise | input | ADDR_W | Shared address, rise half; used as the read address |
| addr_fall | input | ADDR_W | Shared address, fall half; used as the write address |
| wdata_rise | input | LANE_W*LANES | Write data, rise beat |
| wdata_fall | input | LANE_W*LANES | Write data, fall beat |
| ben_rise_n | input | LANES | Active-low byte enables for the rise write beat |
| ben_fall_n | input | LANES | Active-low byte enables for the fall write beat |
| rdata_rise | output | LANE_W*LANES | Read data, rise beat |
| rdata_fall | output | LANE_W*LANES | Read data, fall beat |
| rvalid_rise | output | 1 | Rise read beat valid |
| rvalid_fall | output | 1 | Fall read beat valid |

## Verification
The hardest cases to reach are those where a read snapshot and a write commit meet on the same row in narrow windows. These are a read in the cycle the write is commanded, a read two cycles later, and a read three cycles later; the results must be old, old and new data. Directed sequences place the commands exactly in those cycles. Other directed sequences assert the selects in the blocked slot right after a command. A long run of random selects, addresses and byte enables then lets overlapping bursts collide on the 16-row array often.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int BEATS = 4;
  localparam int PTR_W = $clog2(BEATS);

  // command slot of one port: idle, first data cycle, second data cycle
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_P1   = 2'd1,
    SLOT_P2   = 2'd2
  } slot_e;
endpackage

// File: rtl/qdr_slot.sv
module qdr_slot
  import qdr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel_n,
  output logic  accept,
  output slot_e ph
);
  // a select landing in the first data cycle is ignored (R6)
  assign accept = !sel_n && (ph != SLOT_P1);

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= SLOT_IDLE;
    else if (accept) ph <= SLOT_P1;
    else if (ph == SLOT_P1) ph <= SLOT_P2;
    else ph <= SLOT_IDLE;
  end
endmodule

// File: rtl/qdr_array.sv
module qdr_array
  import qdr_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                                clk,
  input  logic [ROW_W-1:0]                    rd_row,
  output logic [BEATS-1:0][LANE_W*LANES-1:0]  rd_words,
  input  logic                                wr_en,
  input  logic [ROW_W-1:0]                    wr_row,
  input  logic [BEATS-1:0][LANE_W*LANES-1:0]  wr_words,
  input  logic [BEATS-1:0][LANES-1:0]         wr_lanes
);
  localparam int ROWS   = 1 << ROW_W;
  localparam int DATA_W = LANE_W * LANES;

  logic [BEATS-1:0][DATA_W-1:0] mem [ROWS];

  // read sees the contents before any commit at the same edge (R7, R8)
  assign rd_words = mem[rd_row];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < BEATS; k++) begin
        for (int l = 0; l < LANES; l++) begin
          if (wr_lanes[k][l])
            mem[wr_row][k][l*LANE_W +: LANE_W] <= wr_words[k][l*LANE_W +: LANE_W];
        end
      end
    end
  end
endmodule

// File: rtl/qdr_wr_path.sv
module qdr_wr_path
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                accept,
  input  slot_e                               ph,
  input  logic [ADDR_W-1:0]                   addr_fall,
  input  logic [LANE_W*LANES-1:0]             wdata_rise,
  input  logic [LANE_W*LANES-1:0]             wdata_fall,
  input  logic [LANES-1:0]                    ben_rise_n,
  input  logic [LANES-1:0]                    ben_fall_n,
  output logic                                commit,
  output logic [ADDR_W-PTR_W-1:0]             row,
  output logic [BEATS-1:0][LANE_W*LANES-1:0]  words,
  output logic [BEATS-1:0][LANES-1:0]         lanes
);
  localparam int DATA_W = LANE_W * LANES;

  logic [PTR_W-1:0]  start_q;
  logic [DATA_W-1:0] b0_q, b1_q;
  logic [LANES-1:0]  e0_q, e1_q;
  logic [BEATS-1:0][DATA_W-1:0] beat;
  logic [BEATS-1:0][LANES-1:0]  bmask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row     <= '0;
      start_q <= '0;
      b0_q    <= '0;
      b1_q    <= '0;
      e0_q    <= '0;
      e1_q    <= '0;
    end else begin
      if (accept) begin
        row     <= addr_fall[ADDR_W-1:PTR_W];
        start_q <= addr_fall[PTR_W-1:0];
      end
      if (ph == SLOT_P1) begin            // beats 0 and 1 (R4)
        b0_q <= wdata_rise;
        b1_q <= wdata_fall;
        e0_q <= ~ben_rise_n;              // active-low lane enables (R5)
        e1_q <= ~ben_fall_n;
      end
    end
  end

  assign commit = (ph == SLOT_P2);
  assign beat   = {wdata_fall, wdata_rise, b1_q, b0_q};
  assign bmask  = {~ben_fall_n, ~ben_rise_n, e1_q, e0_q};

  // place beat k at word (start + k) mod 4
  always_comb begin
    words = '0;
    lanes = '0;
    for (int k = 0; k < BEATS; k++) begin
      words[start_q + PTR_W'(k)] = beat[k];
      lanes[start_q + PTR_W'(k)] = bmask[k];
    end
  end
endmodule

// File: rtl/qdr_rd_path.sv
module qdr_rd_path
  import qdr_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          accept,
  input  slot_e                         ph,
  input  logic [PTR_W-1:0]              start,
  input  logic [BEATS-1:0][DATA_W-1:0]  row_words,
  output logic [DATA_W-1:0]             rdata_rise,
  output logic [DATA_W-1:0]             rdata_fall,
  output logic                          rvalid_rise,
  output logic                          rvalid_fall
);
  logic [BEATS-1:0][DATA_W-1:0] rot;
  logic [BEATS-1:0][DATA_W-1:0] hold_q;

  // burst order: wrap from the start word (R3)
  always_comb begin
    for (int k = 0; k < BEATS; k++) rot[k] = row_words[start + PTR_W'(k)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q      <= '0;
      rdata_rise  <= '0;
      rdata_fall  <= '0;
      rvalid_rise <= 1'b0;
      rvalid_fall <= 1'b0;
    end else begin
      if (accept) hold_q <= rot;
      // fall half: beat 0 right after capture, beat 2 one cycle later (R2)
      rvalid_fall <= accept || (ph == SLOT_P1);
      if (accept)             rdata_fall <= rot[0];
      else if (ph == SLOT_P1) rdata_fall <= hold_q[2];
      else                    rdata_fall <= '0;
      // rise half: beats 1 and 3
      rvalid_rise <= (ph == SLOT_P1) || (ph == SLOT_P2);
      if (ph == SLOT_P1)      rdata_rise <= hold_q[1];
      else if (ph == SLOT_P2) rdata_rise <= hold_q[3];
      else                    rdata_rise <= '0;
    end
  end
endmodule

// File: rtl/qdr_sram_model.sv
module qdr_sram_model
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_n,
  input  logic                     wr_n,
  input  logic [ADDR_W-1:0]        addr_rise,
  input  logic [ADDR_W-1:0]        addr_fall,
  input  logic [LANE_W*LANES-1:0]  wdata_rise,
  input  logic [LANE_W*LANES-1:0]  wdata_fall,
  input  logic [LANES-1:0]         ben_rise_n,
  input  logic [LANES-1:0]         ben_fall_n,
  output logic [LANE_W*LANES-1:0]  rdata_rise,
  output logic [LANE_W*LANES-1:0]  rdata_fall,
  output logic                     rvalid_rise,
  output logic                     rvalid_fall
);
  localparam int DATA_W = LANE_W * LANES;
  localparam int ROW_W  = ADDR_W - PTR_W;

  logic  rd_acc, wr_acc, wr_commit;
  slot_e rd_ph, wr_ph;
  logic [ROW_W-1:0]             wr_row;
  logic [BEATS-1:0][DATA_W-1:0] rd_words, wr_words;
  logic [BEATS-1:0][LANES-1:0]  wr_lanes;

  // independent slots per port (R6)
  qdr_slot u_rd_slot (.clk(clk), .rst_n(rst_n), .sel_n(rd_n), .accept(rd_acc), .ph(rd_ph));
  qdr_slot u_wr_slot (.clk(clk), .rst_n(rst_n), .sel_n(wr_n), .accept(wr_acc), .ph(wr_ph));

  qdr_array #(.ROW_W(ROW_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk(clk), .rd_row(addr_rise[ADDR_W-1:PTR_W]), .rd_words(rd_words),
    .wr_en(wr_commit), .wr_row(wr_row), .wr_words(wr_words), .wr_lanes(wr_lanes)
  );

  qdr_wr_path #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_wr (
    .clk(clk), .rst_n(rst_n), .accept(wr_acc), .ph(wr_ph), .addr_fall(addr_fall),
    .wdata_rise(wdata_rise), .wdata_fall(wdata_fall),
    .ben_rise_n(ben_rise_n), .ben_fall_n(ben_fall_n),
    .commit(wr_commit), .row(wr_row), .words(wr_words), .lanes(wr_lanes)
  );

  qdr_rd_path #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .accept(rd_acc), .ph(rd_ph),
    .start(addr_rise[PTR_W-1:0]), .row_words(rd_words),
    .rdata_rise(rdata_rise), .rdata_fall(rdata_fall),
    .rvalid_rise(rvalid_rise), .rvalid_fall(rvalid_fall)
  );
endmodule

// File: rtl/qdr_sram_model_chk.sv
module qdr_sram_model_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_n,
  input logic              rvalid_rise,
  input logic              rvalid_fall,
  input logic [DATA_W-1:0] rdata_rise,
  input logic [DATA_W-1:0] rdata_fall
);
  // R2: a rise beat is always preceded by a fall beat of the same burst
  assert_rise_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_rise |-> $past(rvalid_fall));

  // R2: a fall beat is either beat 0 of a read selected last cycle or beat 2
  assert_fall_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_fall |-> ($past(!rd_n) || $past(rvalid_fall)));

  // R1: idle halves carry zero data
  assert_rise_zero_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid_rise |-> (rdata_rise == '0));

  assert_fall_zero_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid_fall |-> (rdata_fall == '0));
endmodule

bind qdr_sram_model qdr_sram_model_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n),
  .rvalid_rise(rvalid_rise), .rvalid_fall(rvalid_fall),
  .rdata_rise(rdata_rise), .rdata_fall(rdata_fall)
);

// File: tb/tb_qdr_sram_model.sv
`timescale 1ns/1ps
module tb_qdr_sram_model;
  localparam int AW = 6;
  localparam int W  = 36;
  localparam int NL = 4;
  localparam int NC = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr_rise = '0, addr_fall = '0;
  logic [W-1:0]  wdata_rise = '0, wdata_fall = '0;
  logic [NL-1:0] ben_rise_n = '1, ben_fall_n = '1;
  logic [W-1:0]  rdata_rise, rdata_fall;
  logic          rvalid_rise, rvalid_fall;

  always #10 clk = ~clk;  // 50 MHz

  qdr_sram_model dut (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr_rise(addr_rise), .addr_fall(addr_fall),
    .wdata_rise(wdata_rise), .wdata_fall(wdata_fall),
    .ben_rise_n(ben_rise_n), .ben_fall_n(ben_fall_n),
    .rdata_rise(rdata_rise), .rdata_fall(rdata_fall),
    .rvalid_rise(rvalid_rise), .rvalid_fall(rvalid_fall)
  );

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R1";

  logic [W-1:0] mdl [64];
  logic         exp_rv [NC];
  logic         exp_fv [NC];
  logic [W-1:0] exp_rd [NC];
  logic [W-1:0] exp_fd [NC];

  logic         rd_busy = 1'b0;
  int           w_ph = 0;
  logic [AW-1:0] w_addr = '0;
  logic [W-1:0] wb [4];
  logic [NL-1:0] we [4];

  function automatic logic [W-1:0] merge(input logic [W-1:0] old_v, input logic [W-1:0] new_v,
                                         input logic [NL-1:0] en);
    logic [W-1:0] r = old_v;
    for (int l = 0; l < NL; l++) if (en[l]) r[l*9 +: 9] = new_v[l*9 +: 9];
    return r;
  endfunction

  function automatic int widx(input logic [AW-1:0] a, input int k);
    logic [1:0] lo = a[1:0] + 2'(k);
    return int'({a[AW-1:2], lo});
  endfunction

  task automatic check_out();
    logic [W-1:0] er = exp_rv[cyc] ? exp_rd[cyc] : '0;
    logic [W-1:0] ef = exp_fv[cyc] ? exp_fd[cyc] : '0;
    total++;
    if (rvalid_rise !== exp_rv[cyc] || rdata_rise !== er) begin
      bad++;
      $display("FAIL %s cyc=%0d rise: got v=%b d=%h exp v=%b d=%h", cur_req, cyc,
               rvalid_rise, rdata_rise, exp_rv[cyc], er);
    end
    total++;
    if (rvalid_fall !== exp_fv[cyc] || rdata_fall !== ef) begin
      bad++;
      $display("FAIL %s cyc=%0d fall: got v=%b d=%h exp v=%b d=%h", cur_req, cyc,
               rvalid_fall, rdata_fall, exp_fv[cyc], ef);
    end
  endtask

  // one input cycle: check outputs, drive inputs, advance the model
  task automatic step(input logic rdn, input logic wrn, input logic [AW-1:0] ar,
                      input logic [AW-1:0] af, input logic [W-1:0] dr, input logic [W-1:0] df,
                      input logic [NL-1:0] brn, input logic [NL-1:0] bfn);
    logic racc, wacc;
    @(negedge clk);
    check_out();
    rd_n = rdn; wr_n = wrn; addr_rise = ar; addr_fall = af;
    wdata_rise = dr; wdata_fall = df; ben_rise_n = brn; ben_fall_n = bfn;
    racc = !rdn && !rd_busy;
    if (racc && cyc + 3 < NC) begin
      exp_fv[cyc+1] = 1'b1; exp_fd[cyc+1] = mdl[widx(ar, 0)];
      exp_rv[cyc+2] = 1'b1; exp_rd[cyc+2] = mdl[widx(ar, 1)];
      exp_fv[cyc+2] = 1'b1; exp_fd[cyc+2] = mdl[widx(ar, 2)];
      exp_rv[cyc+3] = 1'b1; exp_rd[cyc+3] = mdl[widx(ar, 3)];
    end
    rd_busy = racc;
    wacc = !wrn && (w_ph != 1);
    if (w_ph == 1) begin
      wb[0] = dr; wb[1] = df; we[0] = ~brn; we[1] = ~bfn;
    end
    if (w_ph == 2) begin
      wb[2] = dr; wb[3] = df; we[2] = ~brn; we[3] = ~bfn;
      for (int k = 0; k < 4; k++)
        mdl[widx(w_addr, k)] = merge(mdl[widx(w_addr, k)], wb[k], we[k]);
    end
    if (wacc) begin w_ph = 1; w_addr = af; end
    else w_ph = (w_ph == 1) ? 2 : 0;
    @(posedge clk);
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, 1, '0, '0, '0, '0, '1, '1);
  endtask

  task automatic wr_burst(input logic [AW-1:0] a, input logic [W-1:0] d0, input logic [W-1:0] d1,
                          input logic [W-1:0] d2, input logic [W-1:0] d3,
                          input logic [NL-1:0] m01, input logic [NL-1:0] m23);
    step(1, 0, '0, a, '0, '0, '1, '1);
    step(1, 1, '0, '0, d0, d1, m01, m01);
    step(1, 1, '0, '0, d2, d3, m23, m23);
  endtask

  task automatic rd_burst(input logic [AW-1:0] a);
    step(0, 1, a, '0, '0, '0, '1, '1);
    step(1, 1, '0, '0, '0, '0, '1, '1);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog: got running exp finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NC; i++) begin
      exp_rv[i] = 0; exp_fv[i] = 0; exp_rd[i] = '0; exp_fd[i] = '0;
    end
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);

    // R1: reset state observed on the first cycles
    cur_req = "R1";
    idle(2);

    // R4: fill every row with distinct words, full enables
    cur_req = "R4";
    for (int r = 0; r < 16; r++)
      wr_burst(AW'(r * 4), {4'h1, 32'(r*4)}, {4'h2, 32'(r*4+1)}, {4'h3, 32'(r*4+2)},
               {4'h4, 32'(r*4+3)}, '0, '0);
    idle(2);

    // R3 and R2: read with every start offset
    cur_req = "R3";
    for (int s = 0; s < 4; s++) rd_burst(AW'(20 + s));
    idle(2);
    cur_req = "R2";
    rd_burst(6'd7); idle(4);

    // R4: write with a nonzero start offset, then read back
    cur_req = "R4";
    wr_burst(6'd13, 36'hAAAAAAAAA, 36'hBBBBBBBBB, 36'hCCCCCCCCC, 36'hDDDDDDDDD, '0, '0);
    rd_burst(6'd12); idle(3);

    // R5: partial lane enables (bit i low writes lane i)
    cur_req = "R5";
    wr_burst(6'd32, 36'hFFFFFFFFF, 36'hFFFFFFFFF, 36'h123456789, 36'h123456789, 4'b1010, 4'b0110);
    idle(1);
    rd_burst(6'd32); idle(3);
    wr_burst(6'd36, 36'h0, 36'h0, 36'h0, 36'h0, 4'b1111, 4'b1111);
    rd_burst(6'd36); idle(3);

    // R6: selects in the blocked slot are ignored
    cur_req = "R6";
    step(0, 1, 6'd40, '0, '0, '0, '1, '1);
    step(0, 1, 6'd44, '0, '0, '0, '1, '1);
    idle(3);
    step(1, 0, '0, 6'd48, '0, '0, '1, '1);
    step(1, 0, '0, 6'd52, 36'h111111111, 36'h222222222, '0, '0);
    step(1, 1, '0, '0, 36'h333333333, 36'h444444444, '0, '0);
    idle(1);
    rd_burst(6'd48); rd_burst(6'd52); idle(3);

    // R7: read and write to the same row in one cycle
    cur_req = "R7";
    step(0, 0, 6'd56, 6'd57, '0, '0, '1, '1);
    step(1, 1, '0, '0, 36'h0A0A0A0A0, 36'h0B0B0B0B0, '0, '0);
    step(1, 1, '0, '0, 36'h0C0C0C0C0, 36'h0D0D0D0D0, '0, '0);
    idle(1);
    rd_burst(6'd56); idle(3);

    // R8: read two cycles after the write command sees old data, three sees new
    cur_req = "R8";
    step(1, 0, '0, 6'd60, '0, '0, '1, '1);
    step(1, 1, '0, '0, 36'h5A5A5A5A5, 36'h6B6B6B6B6, '0, '0);
    step(0, 1, 6'd61, '0, 36'h7C7C7C7C7, 36'h8D8D8D8D8, '0, '0);
    idle(4);
    step(1, 0, '0, 6'd62, '0, '0, '1, '1);
    step(1, 1, '0, '0, 36'h9E9E9E9E9, 36'hAFAFAFAF0, '0, '0);
    step(1, 1, '0, '0, 36'h101010101, 36'h202020202, '0, '0);
    step(0, 1, 6'd60, '0, '0, '0, '1, '1);
    idle(4);

    // R9: random concurrent traffic, plus a back-to-back read stream
    cur_req = "R9";
    for (int i = 0; i < 8; i++) step(i[0], 1, AW'(i * 5), '0, '0, '0, '1, '1);
    for (int i = 0; i < 2000; i++)
      step(logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)),
           AW'($urandom), AW'($urandom), {4'($urandom), $urandom}, {4'($urandom), $urandom},
           NL'($urandom), NL'($urandom));
    idle(5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule